// File: doc/BRIEF.md
# PRBS-11 Bit Error Meter

This block watches a demodulated serial bit stream that is expected to carry the 2047-bit maximal-length pattern from the recurrence b[n] = b[n-9] XOR b[n-11], which is the polynomial x^11 + x^9 + 1. Each bit arrives with a valid strobe. The meter seeds a local pattern generator from the incoming bits and confirms the alignment over a run of error-free bits. Once locked, it counts every disagreement between the received bit and the local prediction.

Error totals are gathered over fixed windows of valid bits, 1,000,000 by default. The total is published as a 32-bit unsigned value once at the end of each window. Software-style polling reads it as four bytes through a registered byte port. A separate byte reports the lock state. If the error density while locked becomes too high, the meter drops lock and searches again.

Top module: `prbs_ber_meter`

## Requirements
- R1: After reset, sync_o is 0, the published error total is 0 and rd_data_o is 0.
- R2: Acquisition loads the first 11 valid bits into the local generator. The next 64 valid bits must each match the prediction. sync_o rises after the clock edge that takes the 75th valid bit of a clean stream.
- R3: A mismatch during the 64-bit confirmation run abandons it. Loading restarts with the next valid bit, so a clean stream then needs another 75 valid bits before lock.
- R4: Mismatches add to the running total only while the meter is locked. Each such mismatch adds exactly one, and this includes the mismatch that causes loss of lock. Bits seen while loading or confirming add nothing.
- R5: The window counter advances on every valid bit from reset, whether or not the meter is locked. At the edge that takes the last bit of each window, the running total becomes the published total and the running total restarts. At any other time the published total holds its value.
- R6: A read strobe with address a puts a byte on rd_data_o after the next clock edge. Addresses 0 to 3 return bytes 0 to 3 of the total, least significant first. Address 4 returns the lock state in bit 0 and zeros above it. Other addresses return 0. Without a strobe, rd_data_o holds its value.
- R7: Reading does not change or clear the published total.
- R8: A read of address 0 captures the whole published total into a snapshot. Reads of addresses 1 to 3 return bytes of that snapshot, even if a later window has published a new total.
- R9: Lock is lost when a 256-bit span of locked bits holds more than LOSS_LIMIT mismatches. Spans are counted from the lock point. sync_o falls after the offending bit, and acquisition per R2 restarts with the next valid bit.
- R10: Cycles with bit_valid_i low have no effect on lock, acquisition progress or counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Received bit |
| bit_valid_i | input | 1 | bit_i carries a new bit this cycle |
| rd_en_i | input | 1 | Status read strobe |
| rd_addr_i | input | 3 | Status byte address |
| rd_data_o | output | 8 | Registered status byte |
| sync_o | output | 1 | Meter is locked to the pattern |

## Verification
A generator seeded or stepped wrongly gives a lock that comes late or never comes. It can also give a run of false errors right after lock, which the published total shows one window later. A window counter that is off by one bit moves the publish edge, so a read made one bit before the window closes exposes it at once. A missing snapshot only shows once a total of at least 256 changes between two byte reads. The bench therefore builds totals above 255 and publishes a new window between the read of address 0 and the read of address 1.

// File: rtl/prbs_ber_pkg.sv
package prbs_ber_pkg;
  localparam int PRBS_LEN = 11;
  localparam int TAP_OLD  = 10;  // b[n-11]
  localparam int TAP_MID  = 8;   // b[n-9]
  localparam int TOTAL_W  = 32;
  localparam int TOTAL_BYTES = TOTAL_W / 8;
  localparam int ADDR_W   = 3;
  localparam logic [ADDR_W-1:0] ADDR_SYNC = ADDR_W'(TOTAL_BYTES);

  typedef enum logic [1:0] {
    ST_LOAD   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCKED = 2'd2
  } sync_st_e;
endpackage

// File: rtl/prbs11_ref.sv
module prbs11_ref
  import prbs_ber_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic load_i,
  input  logic rx_bit_i,
  output logic pred_o
);
  logic [PRBS_LEN-1:0] hist_q;

  assign pred_o = hist_q[TAP_OLD] ^ hist_q[TAP_MID];

  // load: take received bits; otherwise run free on the prediction
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else if (step_i) hist_q <= {hist_q[PRBS_LEN-2:0], load_i ? rx_bit_i : pred_o};
  end
endmodule

// File: rtl/prbs_sync_ctrl.sv
module prbs_sync_ctrl
  import prbs_ber_pkg::*;
#(
  parameter int SYNC_RUN   = 64,
  parameter int LOSS_SPAN  = 256,
  parameter int LOSS_LIMIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic mismatch_i,
  output logic load_o,
  output logic locked_o,
  output logic count_err_o
);
  localparam int RUN_MAX = (SYNC_RUN > PRBS_LEN) ? SYNC_RUN : PRBS_LEN;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam int SPAN_W  = $clog2(LOSS_SPAN + 1);
  localparam int SERR_W  = $clog2(LOSS_LIMIT + 2);
  localparam logic [RUN_W-1:0]  LOAD_LAST = RUN_W'(PRBS_LEN - 1);
  localparam logic [RUN_W-1:0]  RUN_LAST  = RUN_W'(SYNC_RUN - 1);
  localparam logic [SPAN_W-1:0] SPAN_LAST = SPAN_W'(LOSS_SPAN - 1);
  localparam logic [SERR_W-1:0] ERR_CAP   = SERR_W'(LOSS_LIMIT);

  sync_st_e            st_q;
  logic [RUN_W-1:0]    run_q;
  logic [SPAN_W-1:0]   span_q;
  logic [SERR_W-1:0]   serr_q;

  assign load_o      = (st_q == ST_LOAD);
  assign locked_o    = (st_q == ST_LOCKED);
  assign count_err_o = valid_i && locked_o && mismatch_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_LOAD;
      run_q  <= '0;
      span_q <= '0;
      serr_q <= '0;
    end else if (valid_i) begin
      unique case (st_q)
        ST_LOAD: begin
          if (run_q == LOAD_LAST) begin
            st_q  <= ST_VERIFY;
            run_q <= '0;
          end else begin
            run_q <= run_q + 1'b1;
          end
        end
        ST_VERIFY: begin
          if (mismatch_i) begin
            st_q  <= ST_LOAD;
            run_q <= '0;
          end else if (run_q == RUN_LAST) begin
            st_q   <= ST_LOCKED;
            run_q  <= '0;
            span_q <= '0;
            serr_q <= '0;
          end else begin
            run_q <= run_q + 1'b1;
          end
        end
        ST_LOCKED: begin
          if (mismatch_i && serr_q == ERR_CAP) begin
            st_q  <= ST_LOAD;
            run_q <= '0;
          end else if (span_q == SPAN_LAST) begin
            span_q <= '0;
            serr_q <= '0;
          end else begin
            span_q <= span_q + 1'b1;
            serr_q <= serr_q + SERR_W'(mismatch_i);
          end
        end
        default: st_q <= ST_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/prbs_err_window.sv
module prbs_err_window
  import prbs_ber_pkg::*;
#(
  parameter int WINDOW_BITS = 1000000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               err_i,
  output logic [TOTAL_W-1:0] total_o
);
  localparam int BC_W = (WINDOW_BITS > 1) ? $clog2(WINDOW_BITS) : 1;
  localparam logic [BC_W-1:0] WIN_LAST = BC_W'(WINDOW_BITS - 1);

  logic [BC_W-1:0]    bits_q;
  logic [TOTAL_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q  <= '0;
      acc_q   <= '0;
      total_o <= '0;
    end else if (valid_i) begin
      if (bits_q == WIN_LAST) begin
        bits_q  <= '0;
        acc_q   <= '0;
        total_o <= acc_q + TOTAL_W'(err_i);
      end else begin
        bits_q <= bits_q + 1'b1;
        acc_q  <= acc_q + TOTAL_W'(err_i);
      end
    end
  end
endmodule

// File: rtl/prbs_stat_regs.sv
module prbs_stat_regs
  import prbs_ber_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  input  logic [TOTAL_W-1:0] total_i,
  input  logic               sync_i,
  output logic [7:0]         rd_data_o
);
  logic [TOTAL_W-1:0] snap_q;
  logic [7:0]         snap_byte;

  always_comb begin
    snap_byte = '0;
    for (int k = 1; k < TOTAL_BYTES; k++)
      if (rd_addr_i == ADDR_W'(k)) snap_byte = snap_q[k*8 +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q    <= '0;
      rd_data_o <= '0;
    end else if (rd_en_i) begin
      if (rd_addr_i == '0) begin
        snap_q    <= total_i;
        rd_data_o <= total_i[7:0];
      end else if (rd_addr_i < ADDR_SYNC) begin
        rd_data_o <= snap_byte;
      end else if (rd_addr_i == ADDR_SYNC) begin
        rd_data_o <= {7'b0, sync_i};
      end else begin
        rd_data_o <= '0;
      end
    end
  end
endmodule

// File: rtl/prbs_ber_meter.sv
module prbs_ber_meter
  import prbs_ber_pkg::*;
#(
  parameter int WINDOW_BITS = 1000000,
  parameter int SYNC_RUN    = 64,
  parameter int LOSS_SPAN   = 256,
  parameter int LOSS_LIMIT  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              bit_valid_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              sync_o
);
  logic               pred;
  logic               load;
  logic               count_err;
  logic [TOTAL_W-1:0] err_total;

  prbs11_ref u_ref (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (bit_valid_i),
    .load_i   (load),
    .rx_bit_i (bit_i),
    .pred_o   (pred)
  );

  prbs_sync_ctrl #(
    .SYNC_RUN   (SYNC_RUN),
    .LOSS_SPAN  (LOSS_SPAN),
    .LOSS_LIMIT (LOSS_LIMIT)
  ) u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (bit_valid_i),
    .mismatch_i  (bit_i ^ pred),
    .load_o      (load),
    .locked_o    (sync_o),
    .count_err_o (count_err)
  );

  prbs_err_window #(
    .WINDOW_BITS (WINDOW_BITS)
  ) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (bit_valid_i),
    .err_i   (count_err),
    .total_o (err_total)
  );

  prbs_stat_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .total_i   (err_total),
    .sync_i    (sync_o),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/prbs_ber_chk.sv
module prbs_ber_chk
  import prbs_ber_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bit_valid_i,
  input logic               rd_en_i,
  input logic [ADDR_W-1:0]  rd_addr_i,
  input logic [7:0]         rd_data_o,
  input logic               sync_o,
  input logic [TOTAL_W-1:0] err_total_i
);
  // R2
  lock_on_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> $past(bit_valid_i));
  // R9
  loss_on_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_o) |-> $past(bit_valid_i));
  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_i |=> ($stable(sync_o) && $stable(err_total_i)));
  // R6
  sync_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i == ADDR_SYNC) |=> (rd_data_o == {7'b0, $past(sync_o)}));
  // R6
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
  // R7
  rd_no_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !bit_valid_i) |=> $stable(err_total_i));
endmodule

bind prbs_ber_meter prbs_ber_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bit_valid_i (bit_valid_i),
  .rd_en_i     (rd_en_i),
  .rd_addr_i   (rd_addr_i),
  .rd_data_o   (rd_data_o),
  .sync_o      (sync_o),
  .err_total_i (err_total)
);

// File: tb/prbs_ber_meter_bench.sv
module prbs_ber_meter_bench;
  localparam int WIN   = 1000;
  localparam int LIMIT = 200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_in = 1'b0;
  logic       bit_valid = 1'b0;
  logic       rd_en = 1'b0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       sync;

  int checks = 0;
  int errors = 0;
  logic [10:0] gh;
  int idx;

  always #4 clk = ~clk;

  prbs_ber_meter #(.WINDOW_BITS(WIN), .LOSS_LIMIT(LIMIT)) u_prbs_ber_meter (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(bit_in), .bit_valid_i(bit_valid),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .sync_o(sync)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_valid = 1'b0; rd_en = 1'b0;
    gh = 11'h5A3; idx = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_in = b; bit_valid = 1'b1;
    @(posedge clk); #1;
    bit_valid = 1'b0;
  endtask

  // next pattern bit b[n] = b[n-9] ^ b[n-11], optionally inverted
  task automatic send_prbs(input logic flip);
    logic nb;
    nb = gh[10] ^ gh[8];
    gh = {gh[9:0], nb};
    send_bit(nb ^ flip);
    idx++;
  endtask

  task automatic idle_garbage();
    @(negedge clk);
    bit_in = ~bit_in; bit_valid = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
    d = int'(rd_data);
  endtask

  task automatic t_reset();
    int d;
    do_reset();
    chk("R1 sync after reset", int'(sync), 0);
    chk("R1 rd_data after reset", int'(rd_data), 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk("R1 status byte after reset", d, 0);
    end
  endtask

  task automatic t_acquire();
    int d;
    do_reset();
    for (int i = 0; i < 74; i++) begin
      send_prbs(1'b0);
      idle_garbage();  // R10: invalid cycles carry junk
      idle_garbage();
    end
    chk("R2 R10 no lock after 74 bits", int'(sync), 0);
    send_prbs(1'b0);
    chk("R2 R10 lock after 75 bits", int'(sync), 1);
    rd(3'd4, d);
    chk("R6 sync byte", d, 1);
    rd(3'd6, d);
    chk("R6 unmapped address", d, 0);
  endtask

  task automatic t_verify_restart();
    do_reset();
    while (idx < 115) send_prbs(idx == 40);
    chk("R3 no lock before restarted run ends", int'(sync), 0);
    send_prbs(1'b0);
    chk("R3 lock after restart", int'(sync), 1);
  endtask

  task automatic t_window();
    int d;
    do_reset();
    // idx 20 hits confirmation (not counted); 300 errors after lock at idx 95
    while (idx < WIN - 1) send_prbs(idx == 20 || (idx >= 100 && idx < 700 && idx % 2 == 0));
    rd(3'd0, d);
    chk("R5 total holds before window end", d, 0);
    send_prbs(1'b0);
    rd(3'd0, d); chk("R4 R6 byte0 of 300", d, 8'h2C);
    rd(3'd1, d); chk("R6 byte1 of 300", d, 8'h01);
    rd(3'd2, d); chk("R6 byte2 of 300", d, 0);
    rd(3'd3, d); chk("R6 byte3 of 300", d, 0);
    rd(3'd0, d); chk("R7 reread not cleared", d, 8'h2C);
    while (idx < 2 * WIN - 1) send_prbs(idx < 1200 && idx % 2 == 0);
    rd(3'd0, d); chk("R5 old total mid window", d, 8'h2C);
    send_prbs(1'b0);
    rd(3'd1, d); chk("R8 snapshot byte1 kept", d, 8'h01);
    rd(3'd0, d); chk("R5 second window total", d, 8'h64);
    rd(3'd1, d); chk("R8 new snapshot byte1", d, 0);
  endtask

  task automatic t_loss();
    int d;
    do_reset();
    while (idx < 75) send_prbs(1'b0);
    chk("R9 locked before burst", int'(sync), 1);
    while (idx < 75 + LIMIT) send_prbs(1'b1);
    chk("R9 holds at limit", int'(sync), 1);
    send_prbs(1'b1);
    chk("R9 drops past limit", int'(sync), 0);
    while (idx < 350) send_prbs(1'b0);
    chk("R9 reacquire not early", int'(sync), 0);
    send_prbs(1'b0);
    chk("R9 reacquired", int'(sync), 1);
    while (idx < WIN) send_prbs(1'b0);
    rd(3'd0, d);
    chk("R4 burst counted incl. dropping bit", d, LIMIT + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_acquire();
    t_verify_restart();
    t_window();
    t_loss();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule